// File: doc/BRIEF.md
# Pipeline Issue Interlock Scoreboard

This block is the issue-control logic of a five-stage in-order pipeline (fetch, decode, execute, memory access, writeback). Each cycle decode presents at most one instruction: a class code, a destination register index and up to three source register indices, each with its own enable. The block decides in the same cycle whether that instruction may leave decode. It raises `stall` when the instruction must wait and `issue_fire` when it is accepted.

Two kinds of hazard are tracked. First, every register has a countdown that says how long it stays unreadable after a writer is accepted. The countdown comes from the writer's class latency, and a later writer to the same register can never shorten it. Second, a single timer covers the memory-access stage. Long-running classes hold that stage for many cycles, and while they do, every later instruction is blocked, even one with no data dependence.

Timing convention: an instruction accepted in cycle t reads its sources in cycle t+1 and enters memory access in cycle t+2. A class with result latency L makes its result readable in cycle t+L. A dependent instruction may therefore be accepted in cycle t+L-1 at the earliest. A class that occupies memory access for M cycles lets the next instruction be accepted in cycle t+M at the earliest.

Top module: `issue_interlock`

## Requirements
- R1: A synchronous active-high `rst` clears every register countdown and the memory-access timer, so on the first cycle after reset any valid instruction is accepted at once.
- R2: `issue_fire` is 1 exactly when `dec_valid` is 1 and no hazard exists. `stall` is 1 exactly when `dec_valid` is 1 and a hazard exists. When `dec_valid` is 0, both outputs are 0.
- R3: Short-latency writers and their results. A writer accepted in cycle t with latency L blocks a reader of its destination until cycle t+L-1. The latencies are L=2 for ALU (code 0), multiply (1), float compare (13) and stream get (14); L=3 for shift (3); L=4 for branch-and-link (6) and load (17). Each of these occupies memory access for 1 cycle.
- R4: Long-latency writers, given as L / memory-access cycles. Integer divide (2) is 33/31. Float op (8) is 5/2. Float divide (9) is 29/26. Float-to-int (10) is 6/3. Int-to-float (11) is 5/2. Square root (12) is 28/25.
- R5: After a class with occupancy M is accepted in cycle t, no instruction is accepted before cycle t+M, whether or not it depends on that class. Cache control (7) has occupancy 2.
- R6: Classes without a result never mark their destination field busy. These are branch (4), conditional branch (5), cache control (7), stream put (15) and store (16).
- R7: Register index 0 is never busy, even when it is the destination of a writer.
- R8: A source index whose enable bit is 0 never causes a stall. Bit 0 of `dec_src_en` enables `dec_src_a`, bit 1 enables `dec_src_b` and bit 2 enables `dec_src_c`.
- R9: When a younger writer targets a register that already has a pending result, the register keeps the later of the two ready times.
- R10: Class codes 18 to 31 write no register and occupy memory access for 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_class | input | 5 | Instruction class code |
| dec_dst | input | REG_W (5) | Destination register index |
| dec_src_en | input | 3 | Enables for the three source indices |
| dec_src_a | input | REG_W (5) | First source register index |
| dec_src_b | input | REG_W (5) | Second source register index |
| dec_src_c | input | REG_W (5) | Third source register index |
| stall | output | 1 | The presented instruction must wait |
| issue_fire | output | 1 | The presented instruction is accepted this cycle |

## Verification
Both outputs are combinational in the presented instruction and in the state registered at the previous edge. They are due in the same cycle the instruction is driven. The bench drives on the falling edge and compares one time unit later, before the rising edge that commits an acceptance.

The reference model keeps absolute cycle numbers. For each register it stores the first cycle in which a reader may be accepted, which is acceptance plus L-1. It also stores the first cycle in which memory access is free, which is acceptance plus M. Directed sequences then count stall cycles and check them against L-2 or M-1, whichever is larger, for every class.

// File: rtl/issue_pkg.sv
package issue_pkg;

  localparam int CLS_W  = 5;
  localparam int TIME_W = 6;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU     = 5'd0,
    CL_MUL     = 5'd1,
    CL_IDIV    = 5'd2,
    CL_SHIFT   = 5'd3,
    CL_BR      = 5'd4,
    CL_BRCOND  = 5'd5,
    CL_BRLINK  = 5'd6,
    CL_CACHE   = 5'd7,
    CL_FPU     = 5'd8,
    CL_FDIV    = 5'd9,
    CL_F2I     = 5'd10,
    CL_I2F     = 5'd11,
    CL_FSQRT   = 5'd12,
    CL_FCMP    = 5'd13,
    CL_SGET    = 5'd14,
    CL_SPUT    = 5'd15,
    CL_STORE   = 5'd16,
    CL_LOAD    = 5'd17
  } iclass_e;

  typedef struct packed {
    logic              writes;
    logic [TIME_W-1:0] lat;
    logic [TIME_W-1:0] occ;
  } class_info_t;

endpackage

// File: rtl/class_timing_decode.sv
module class_timing_decode
  import issue_pkg::*;
(
  input  logic [CLS_W-1:0] cls_code,
  output class_info_t      info
);

  function automatic class_info_t mk(input logic w, input int l, input int o);
    class_info_t r;
    r.writes = w;
    r.lat    = TIME_W'(l);
    r.occ    = TIME_W'(o);
    return r;
  endfunction

  always_comb begin
    case (cls_code)
      CL_ALU, CL_MUL, CL_FCMP, CL_SGET: info = mk(1'b1, 2, 1);
      CL_SHIFT:                         info = mk(1'b1, 3, 1);
      CL_BRLINK, CL_LOAD:               info = mk(1'b1, 4, 1);
      CL_IDIV:                          info = mk(1'b1, 33, 31);
      CL_FPU, CL_I2F:                   info = mk(1'b1, 5, 2);
      CL_F2I:                           info = mk(1'b1, 6, 3);
      CL_FDIV:                          info = mk(1'b1, 29, 26);
      CL_FSQRT:                         info = mk(1'b1, 28, 25);
      CL_CACHE:                         info = mk(1'b0, 0, 2);
      default:                          info = mk(1'b0, 0, 1);
    endcase
  end

endmodule

// File: rtl/reg_ready_table.sv
module reg_ready_table #(
  parameter int NREG   = 32,
  parameter int REG_W  = $clog2(NREG),
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_idx,
  input  logic [TIME_W-1:0] wr_hold,
  output logic [NREG-1:0]   busy
);

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
        assign busy[g] = 1'b0;
      end else begin : g_cnt
        logic [TIME_W-1:0] cnt;
        logic [TIME_W-1:0] dec;
        logic              hit;

        assign dec = (cnt == '0) ? '0 : cnt - 1'b1;
        assign hit = wr_en && (wr_idx == REG_W'(g));

        always_ff @(posedge clk) begin
          if (rst) begin
            cnt <= '0;
          end else if (hit && (wr_hold > dec)) begin
            cnt <= wr_hold;
          end else begin
            cnt <= dec;
          end
        end

        assign busy[g] = (cnt != '0);
      end
    end
  endgenerate

endmodule

// File: rtl/stage_occupancy_timer.sv
module stage_occupancy_timer #(
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [TIME_W-1:0] load_val,
  output logic              busy
);

  logic [TIME_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load_en) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import issue_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic [4:0]       dec_class,
  input  logic [REG_W-1:0] dec_dst,
  input  logic [2:0]       dec_src_en,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] dec_src_c,
  output logic             stall,
  output logic             issue_fire
);

  class_info_t       info;
  logic [NREG-1:0]   reg_busy;
  logic              ma_busy;
  logic              data_hz;
  logic              hazard;
  logic              wr_en;
  logic [TIME_W-1:0] wr_hold;
  logic [TIME_W-1:0] occ_hold;

  class_timing_decode u_dec (
    .cls_code (dec_class),
    .info     (info)
  );

  assign data_hz = (dec_src_en[0] && reg_busy[dec_src_a])
                || (dec_src_en[1] && reg_busy[dec_src_b])
                || (dec_src_en[2] && reg_busy[dec_src_c]);
  assign hazard     = data_hz || ma_busy;
  assign stall      = dec_valid && hazard;
  assign issue_fire = dec_valid && !hazard;

  assign wr_en    = issue_fire && info.writes && (dec_dst != '0);
  assign wr_hold  = info.lat - TIME_W'(2);
  assign occ_hold = info.occ - TIME_W'(1);

  reg_ready_table #(
    .NREG   (NREG),
    .REG_W  (REG_W),
    .TIME_W (TIME_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (dec_dst),
    .wr_hold (wr_hold),
    .busy    (reg_busy)
  );

  stage_occupancy_timer #(
    .TIME_W (TIME_W)
  ) u_ma (
    .clk      (clk),
    .rst      (rst),
    .load_en  (issue_fire),
    .load_val (occ_hold),
    .busy     (ma_busy)
  );

endmodule

// File: rtl/interlock_checker.sv
module interlock_checker
  import issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_valid,
  input logic [4:0]       dec_class,
  input logic [REG_W-1:0] dec_dst,
  input logic [2:0]       dec_src_en,
  input logic [REG_W-1:0] dec_src_a,
  input logic             stall,
  input logic             issue_fire
);

  AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    stall |-> dec_valid); // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(stall && issue_fire)); // R2

  AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && dec_valid) |-> issue_fire); // R1

  AST_IDIV_HOLDS_STAGE: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && dec_class == CL_IDIV) |=> !issue_fire); // R5

  AST_CACHE_HOLDS_STAGE: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && dec_class == CL_CACHE) |=> !issue_fire); // R5

  AST_SHIFT_DEP_WAITS: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && dec_class == CL_SHIFT && dec_dst != '0) |=>
      !(issue_fire && dec_src_en[0] && dec_src_a == $past(dec_dst))); // R3

endmodule

bind issue_interlock interlock_checker #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dec_valid  (dec_valid),
  .dec_class  (dec_class),
  .dec_dst    (dec_dst),
  .dec_src_en (dec_src_en),
  .dec_src_a  (dec_src_a),
  .stall      (stall),
  .issue_fire (issue_fire)
);

// File: tb/tb_issue_interlock.sv
module tb_issue_interlock;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid = 1'b0;
  logic [4:0] dec_class = '0;
  logic [4:0] dec_dst = '0;
  logic [2:0] dec_src_en = '0;
  logic [4:0] dec_src_a = '0;
  logic [4:0] dec_src_b = '0;
  logic [4:0] dec_src_c = '0;
  logic       stall;
  logic       issue_fire;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ready_at [32];
  int ma_free = 0;
  int wd = 0;

  always #2 clk = ~clk;

  issue_interlock dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
    .dec_dst(dec_dst), .dec_src_en(dec_src_en), .dec_src_a(dec_src_a),
    .dec_src_b(dec_src_b), .dec_src_c(dec_src_c),
    .stall(stall), .issue_fire(issue_fire)
  );

  // Class table taken from the requirements: writes, latency, occupancy.
  task automatic spec(input int c, output bit w, output int l, output int o);
    w = 1; o = 1;
    case (c)
      0, 1, 13, 14: l = 2;
      3:            l = 3;
      6, 17:        l = 4;
      2:  begin l = 33; o = 31; end
      8, 11: begin l = 5; o = 2; end
      9:  begin l = 29; o = 26; end
      10: begin l = 6; o = 3; end
      12: begin l = 28; o = 25; end
      7:  begin w = 0; l = 0; o = 2; end
      default: begin w = 0; l = 0; end
    endcase
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 32; i++) ready_at[i] = 0;
    ma_free = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dec_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk);
    model_clear();
    cyc += 2;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input string tag, input bit v, input int c, input int d,
                      input bit [2:0] en, input int a, input int b, input int s,
                      output bit acc);
    bit hz; bit w; int l; int o;
    @(negedge clk);
    dec_valid = v; dec_class = 5'(c); dec_dst = 5'(d); dec_src_en = en;
    dec_src_a = 5'(a); dec_src_b = 5'(b); dec_src_c = 5'(s);
    #1;
    hz = (cyc < ma_free)
      || (en[0] && a != 0 && cyc < ready_at[a])
      || (en[1] && b != 0 && cyc < ready_at[b])
      || (en[2] && s != 0 && cyc < ready_at[s]);
    acc = v && !hz;
    chk({tag, " stall"}, int'(stall), int'(v && hz));
    chk({tag, " issue_fire"}, int'(issue_fire), int'(acc));
    @(posedge clk);
    if (acc) begin
      spec(c, w, l, o);
      if (w && d != 0 && ready_at[d] < cyc + l - 1) ready_at[d] = cyc + l - 1;
      ma_free = cyc + o;
    end
    cyc++;
  endtask

  task automatic issue(input string tag, input int c, input int d, input bit [2:0] en,
                       input int a, input int b, input int s, output int waits);
    bit acc;
    waits = 0;
    for (int k = 0; k < 80; k++) begin
      step(tag, 1'b1, c, d, en, a, b, s, acc);
      if (acc) break;
      waits++;
    end
  endtask

  task automatic pair(input string tag, input int c, input int d, input int exp_w);
    int w;
    issue({tag, " writer"}, c, d, 3'b000, 0, 0, 0, w);
    issue({tag, " reader"}, 0, 20, 3'b001, d, 0, 0, w);
    chk({tag, " reader waits"}, w, exp_w);
  endtask

  task automatic drain();
    bit acc;
    for (int k = 0; k < 40; k++) step("drain idle R2", 1'b0, 0, 0, 3'b000, 0, 0, 0, acc);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int w;
    bit acc;
    model_clear();
    do_reset();

    // R1 and R2: reset state and idle cycle
    step("R2 idle", 1'b0, 0, 1, 3'b111, 1, 2, 3, acc);
    step("R1 first after reset", 1'b1, 0, 1, 3'b111, 1, 2, 3, acc);
    chk("R1 accepted at once", int'(acc), 1);
    drain();

    // R3 short latencies
    pair("R3 alu", 0, 1, 0);
    pair("R3 mul", 1, 1, 0);
    pair("R3 fcmp", 13, 2, 0);
    pair("R3 sget", 14, 2, 0);
    pair("R3 shift", 3, 3, 1);
    pair("R3 brlink", 6, 4, 2);
    pair("R3 load", 17, 5, 2);
    drain();

    // R4 long latencies (reader waits max(L-2, M-1))
    pair("R4 idiv", 2, 6, 31);
    pair("R4 fpu", 8, 7, 3);
    pair("R4 fdiv", 9, 8, 27);
    pair("R4 f2i", 10, 9, 4);
    pair("R4 i2f", 11, 10, 3);
    pair("R4 fsqrt", 12, 11, 26);
    drain();

    // R5 stage occupancy blocks independent work
    issue("R5 idiv", 2, 12, 3'b000, 0, 0, 0, w);
    issue("R5 independent", 0, 13, 3'b000, 0, 0, 0, w);
    chk("R5 independent waits after idiv", w, 30);
    issue("R5 cache", 7, 0, 3'b011, 1, 2, 0, w);
    issue("R5 after cache", 0, 13, 3'b000, 0, 0, 0, w);
    chk("R5 waits after cache", w, 1);
    drain();

    // R6 no-result classes leave destination free
    pair("R6 branch", 4, 14, 0);
    pair("R6 brcond", 5, 14, 0);
    pair("R6 sput", 15, 14, 0);
    pair("R6 store", 16, 14, 0);
    drain();

    // R7 register zero
    pair("R7 load r0", 17, 0, 0);
    pair("R7 idiv r0", 2, 0, 30);
    drain();

    // R8 disabled sources ignored, each slot checked
    issue("R8 load", 17, 15, 3'b000, 0, 0, 0, w);
    issue("R8 disabled", 0, 16, 3'b000, 15, 15, 15, w);
    chk("R8 disabled sources no wait", w, 0);
    drain();
    issue("R8 load b", 17, 15, 3'b000, 0, 0, 0, w);
    issue("R8 slot b", 0, 16, 3'b010, 0, 15, 0, w);
    chk("R8 slot b waits", w, 2);
    drain();
    issue("R8 load c", 17, 15, 3'b000, 0, 0, 0, w);
    issue("R8 slot c", 0, 16, 3'b100, 0, 0, 15, w);
    chk("R8 slot c waits", w, 2);
    drain();

    // R9 younger short writer keeps the older ready time
    issue("R9 load", 17, 17, 3'b000, 0, 0, 0, w);
    issue("R9 alu same dst", 0, 17, 3'b000, 0, 0, 0, w);
    issue("R9 reader", 0, 18, 3'b001, 17, 0, 0, w);
    chk("R9 reader waits for older", w, 1);
    drain();

    // R10 undefined codes
    pair("R10 code 25", 25, 19, 0);
    pair("R10 code 31", 31, 19, 0);
    drain();

    // R1 reset mid-flight clears pending state
    issue("R1 idiv pending", 2, 21, 3'b000, 0, 0, 0, w);
    do_reset();
    issue("R1 reader after reset", 0, 22, 3'b001, 21, 0, 0, w);
    chk("R1 no wait after reset", w, 0);
    drain();

    // Mixed random stream, instruction held while stalled
    for (int n = 0; n < 3000; n++) begin
      int c; int d; int a; int b; int s;
      if ($urandom % 10 == 0) c = int'($urandom % 32);
      else begin
        case ($urandom % 8)
          0: c = 0; 1: c = 3; 2: c = 17; 3: c = 6;
          4: c = 16; 5: c = 8; 6: c = 10; default: c = 13;
        endcase
      end
      d = int'($urandom % 8); a = int'($urandom % 8);
      b = int'($urandom % 8); s = int'($urandom % 8);
      if ($urandom % 6 == 0) step("R2 random idle", 1'b0, c, d, 3'b111, a, b, s, acc);
      else issue("R2 random", c, d, 3'($urandom), a, b, s, w);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule